// File: doc/BRIEF.md
# Byte-Lane DRAM Module Controller

This controller sits between a single requester and a memory module made of eight byte-wide DRAM chips that together store 64-bit doublewords. A request carries a doubleword address. The controller splits that address into a row field and a column field and sends one shared row/column bus to all eight chips, so every chip opens the same supercell. Chip k owns byte lane k of the doubleword.

Each request runs through two phases. In the address phase the requester presents the address while the controller is idle. For a write, a data phase follows, possibly some cycles later, and the controller captures the doubleword. The controller then drives a row strobe for one cycle and a column strobe in the next cycle. A write is committed on the column cycle. A read waits until all eight lanes report valid data in the same cycle, then assembles the 64-bit result. A one-cycle done pulse closes every transaction.

Top module: `dram_lane_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o`, `dram_ras_o`, `dram_cas_o` and `dram_we_o` are 0, and `rdata_o` is 0. `ready_o` is 1 only while the controller is idle, and a request is accepted on a clock edge where `req_valid_i` and `ready_o` are both 1.
- R2: The cycle after a read is accepted, `dram_ras_o` is 1 for exactly one cycle, with `dram_row_o` equal to `req_addr_i[ADDR_W-1:COL_W]`. In the next cycle `dram_cas_o` is 1 for one cycle, with `dram_col_o` equal to `req_addr_i[COL_W-1:0]`.
- R3: After a write is accepted, `wdata_ready_o` stays 1 and no strobe is issued until a cycle with `wdata_valid_i` = 1. The row strobe follows in the next cycle and the column strobe in the cycle after that. `dram_we_o` is 1 only in that column cycle.
- R4: During the write column cycle, chip lane k (`dram_wdata_o[8k+7:8k]`) carries bits 8k+7:8k of the captured write doubleword.
- R5: In the read phase, a cycle in which any of the eight `dram_rvalid_i` bits is 0 captures nothing. `rdata_o` keeps its value and `done_o` stays 0.
- R6: When all eight `dram_rvalid_i` bits are 1 in the same read-phase cycle, `rdata_o` takes `dram_rdata_i`, with lane k in bits 8k+7:8k.
- R7: `done_o` is a single-cycle pulse. It comes in the cycle after the write column strobe, or in the cycle after the read capture. The controller is idle again in the following cycle.
- R8: While the controller is busy, `ready_o` is 0 and a request on `req_valid_i` has no effect: the row and column sent to the chips stay those of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Address phase request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Doubleword address, row field on top |
| ready_o | output | 1 | Controller idle, request can be accepted |
| wdata_valid_i | input | 1 | Write data phase valid |
| wdata_i | input | 64 | Write doubleword |
| wdata_ready_o | output | 1 | Waiting for the write data phase |
| rdata_o | output | 64 | Last assembled read doubleword |
| done_o | output | 1 | Transaction complete pulse |
| dram_row_o | output | ROW_W | Row address shared by all chips |
| dram_col_o | output | COL_W | Column address shared by all chips |
| dram_ras_o | output | 1 | Row strobe |
| dram_cas_o | output | 1 | Column strobe |
| dram_we_o | output | 1 | Write enable, valid with the column strobe |
| dram_wdata_o | output | 64 | Write bytes, lane k to chip k |
| dram_rdata_i | input | 64 | Read bytes, lane k from chip k |
| dram_rvalid_i | input | 8 | Per-lane read valid |

## Verification
Reads and writes are mixed at random over a small pool of row/column values plus the all-ones corner. This lets a read return bytes that an earlier write left in each chip, and exposes any lane swap or address field mix-up. Write data phases come after gaps of varying length, which separates true data-phase sequencing from a fixed delay. Reads are answered after varying delays, some preceded by a cycle with only part of the lanes valid, which tells an all-lanes capture apart from one that reacts to any lane. Directed cases send a second request into a busy controller to show it is ignored.

// File: rtl/dram_lane_pkg.sv
package dram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WDATA  = 3'd1,
    ST_ROW    = 3'd2,
    ST_COL    = 3'd3,
    ST_RDWAIT = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= addr_i[ADDR_W-1:COL_W];
      col_q <= addr_i[COL_W-1:0];
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_lane_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  input  logic wdata_valid_i,
  input  logic lanes_all_i,
  output logic ready_o,
  output logic wdata_ready_o,
  output logic addr_load_o,
  output logic wdata_load_o,
  output logic ras_o,
  output logic cas_o,
  output logic we_o,
  output logic capture_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       we_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = req_we_i ? ST_WDATA : ST_ROW;
      ST_WDATA:  if (wdata_valid_i) state_d = ST_ROW;
      ST_ROW:    state_d = ST_COL;
      ST_COL:    state_d = we_q ? ST_DONE : ST_RDWAIT;
      ST_RDWAIT: if (lanes_all_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (addr_load_o) we_q <= req_we_i;
    end
  end

  assign ready_o       = (state_q == ST_IDLE);
  assign wdata_ready_o = (state_q == ST_WDATA);
  assign addr_load_o   = ready_o && req_valid_i;
  assign wdata_load_o  = wdata_ready_o && wdata_valid_i;
  assign ras_o         = (state_q == ST_ROW);
  assign cas_o         = (state_q == ST_COL);
  assign we_o          = cas_o && we_q;
  assign capture_o     = (state_q == ST_RDWAIT) && lanes_all_i;
  assign done_o        = (state_q == ST_DONE);

  AST_RAS_THEN_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_o |=> !ras_o && cas_o); // R2
  AST_CAS_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |-> $past(ras_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o); // R7
  AST_RAS_AFTER_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_o) |-> $past(ready_o) || $past(wdata_ready_o)); // R3
endmodule

// File: rtl/dram_lane_gather.sv
module dram_lane_gather #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdata_load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] lane_rdata_i,
  input  logic [LANES-1:0]  lane_valid_i,
  output logic              lanes_all_o,
  output logic [DATA_W-1:0] lane_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign lanes_all_o = &lane_valid_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] wbyte_q;
    logic [LANE_W-1:0] rbyte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wbyte_q <= '0;
        rbyte_q <= '0;
      end else begin
        if (wdata_load_i) wbyte_q <= wdata_i[k*LANE_W +: LANE_W];
        if (capture_i)    rbyte_q <= lane_rdata_i[k*LANE_W +: LANE_W];
      end
    end

    assign lane_wdata_o[k*LANE_W +: LANE_W] = wbyte_q;
    assign rdata_o[k*LANE_W +: LANE_W]      = rbyte_q;
  end

  AST_CAPTURE_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(&lane_valid_i)); // R5
endmodule

// File: rtl/dram_lane_ctrl.sv
module dram_lane_ctrl #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              ready_o,
  input  logic              wdata_valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ROW_W-1:0]  dram_row_o,
  output logic [COL_W-1:0]  dram_col_o,
  output logic              dram_ras_o,
  output logic              dram_cas_o,
  output logic              dram_we_o,
  output logic [DATA_W-1:0] dram_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i,
  input  logic [LANES-1:0]  dram_rvalid_i
);
  logic addr_load, wdata_load, lanes_all, capture;

  dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_load),
    .addr_i (req_addr_i),
    .row_o  (dram_row_o),
    .col_o  (dram_col_o)
  );

  dram_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_we_i      (req_we_i),
    .wdata_valid_i (wdata_valid_i),
    .lanes_all_i   (lanes_all),
    .ready_o       (ready_o),
    .wdata_ready_o (wdata_ready_o),
    .addr_load_o   (addr_load),
    .wdata_load_o  (wdata_load),
    .ras_o         (dram_ras_o),
    .cas_o         (dram_cas_o),
    .we_o          (dram_we_o),
    .capture_o     (capture),
    .done_o        (done_o)
  );

  dram_lane_gather #(.LANES(LANES), .LANE_W(LANE_W)) u_gather (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdata_load_i (wdata_load),
    .wdata_i      (wdata_i),
    .capture_i    (capture),
    .lane_rdata_i (dram_rdata_i),
    .lane_valid_i (dram_rvalid_i),
    .lanes_all_o  (lanes_all),
    .lane_wdata_o (dram_wdata_o),
    .rdata_o      (rdata_o)
  );

  AST_BUSY_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(dram_row_o) && $stable(dram_col_o)); // R8
  AST_WE_ONLY_ON_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |-> $past(dram_ras_o)); // R3
endmodule

// File: tb/dram_lane_ctrl_bench.sv
module dram_lane_ctrl_bench;
  localparam int ROW_W = 12, COL_W = 10, ADDR_W = 22;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 0, req_we = 0, wdata_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0] wdata = '0, dram_rdata = '0;
  logic [7:0]  dram_rvalid = '0;
  logic ready, wdata_ready, done, ras, cas, we;
  logic [63:0] rdata, dram_wdata;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0]  chip_mem [int];
  logic [63:0] ref_mem  [int];
  logic [63:0] last_rd = '0;

  always #4 clk = ~clk;

  dram_lane_ctrl u_dram_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .ready_o(ready), .wdata_valid_i(wdata_valid),
    .wdata_i(wdata), .wdata_ready_o(wdata_ready), .rdata_o(rdata), .done_o(done),
    .dram_row_o(row), .dram_col_o(col), .dram_ras_o(ras), .dram_cas_o(cas),
    .dram_we_o(we), .dram_wdata_o(dram_wdata), .dram_rdata_i(dram_rdata),
    .dram_rvalid_i(dram_rvalid)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] def_byte(int lane, logic [ADDR_W-1:0] a);
    return 8'(a * 7 + lane * 31 + 5);
  endfunction

  function automatic logic [63:0] exp_read(logic [ADDR_W-1:0] a);
    logic [63:0] v;
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    for (int k = 0; k < 8; k++) v[8*k +: 8] = def_byte(k, a);
    return v;
  endfunction

  function automatic logic [63:0] chip_read(logic [ADDR_W-1:0] a);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) begin
      int key = (k << ADDR_W) | int'(a);
      v[8*k +: 8] = chip_mem.exists(key) ? chip_mem[key] : def_byte(k, a);
    end
    return v;
  endfunction

  task automatic do_write(logic [ADDR_W-1:0] a, logic [63:0] d, int gap);
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready idle", 64'(ready), 64'd1);
    req_valid = 1; req_we = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0; req_we = 0; req_addr = ~a;
    chk(wdata_ready == 1'b1 && ready == 1'b0, "R3 data phase wait", 64'({wdata_ready, ready}), 64'b10);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(ras == 1'b0 && wdata_ready == 1'b1, "R3 no strobe before data", 64'({ras, wdata_ready}), 64'b01);
    end
    wdata_valid = 1; wdata = d;
    @(negedge clk);
    wdata_valid = 0; wdata = ~d;
    chk(ras && !cas && row == a[ADDR_W-1:COL_W], "R2 write row strobe", 64'(row), 64'(a[ADDR_W-1:COL_W]));
    @(negedge clk);
    chk(cas && !ras && we && col == a[COL_W-1:0], "R3 write col strobe", 64'({we, col}), 64'({1'b1, a[COL_W-1:0]}));
    for (int k = 0; k < 8; k++) begin
      chk(dram_wdata[8*k +: 8] == d[8*k +: 8], "R4 lane byte", 64'(dram_wdata[8*k +: 8]), 64'(d[8*k +: 8]));
      chip_mem[(k << ADDR_W) | int'(a)] = dram_wdata[8*k +: 8];
    end
    ref_mem[int'(a)] = d;
    @(negedge clk);
    chk(done && !we && !cas, "R7 write done", 64'({done, we}), 64'b10);
    @(negedge clk);
    chk(!done && ready, "R7 done single", 64'({done, ready}), 64'b01);
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, int lat, bit partial, bit busy_req);
    logic [63:0] e;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready idle", 64'(ready), 64'd1);
    req_valid = 1; req_we = 0; req_addr = a;
    @(negedge clk);
    if (busy_req) begin
      req_addr = ~a; req_we = 1;
      chk(ready == 1'b0, "R8 busy not ready", 64'(ready), 64'd0);
    end else req_valid = 0;
    chk(ras && !cas && row == a[ADDR_W-1:COL_W], "R2 read row strobe", 64'(row), 64'(a[ADDR_W-1:COL_W]));
    @(negedge clk);
    req_valid = 0; req_we = 0;
    chk(cas && !ras && !we && col == a[COL_W-1:0], "R2 read col strobe", 64'({we, col}), 64'(a[COL_W-1:0]));
    chk(row == a[ADDR_W-1:COL_W], "R8 row kept", 64'(row), 64'(a[ADDR_W-1:COL_W]));
    @(negedge clk);
    if (partial) begin
      dram_rvalid = 8'($urandom_range(1, 254));
      dram_rdata  = {$urandom, $urandom};
      @(negedge clk);
      dram_rvalid = '0;
      chk(!done && rdata == last_rd, "R5 partial ignored", rdata, last_rd);
    end
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk(!done, "R5 no done before data", 64'(done), 64'd0);
    dram_rvalid = 8'hFF; dram_rdata = chip_read(a);
    @(negedge clk);
    dram_rvalid = '0; dram_rdata = '0;
    e = exp_read(a);
    chk(done && rdata == e, "R6 read data", rdata, e);
    last_rd = e;
    @(negedge clk);
    chk(!done && ready, "R7 done single", 64'({done, ready}), 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(ready && !done && !ras && !cas && !we && rdata == 0 && !wdata_ready, "R1 reset state",
        {55'd0, ready, done, ras, cas, we, wdata_ready, 2'b0}, 64'h80);
    rst_ni = 1;
    // directed corners
    do_read(22'h000000, 0, 0, 0);
    do_write(22'h3FFFFF, 64'h0123_4567_89AB_CDEF, 0);
    do_read(22'h3FFFFF, 2, 1, 1);
    do_write(22'h000401, 64'hFF00_FF00_A5A5_5A5A, 5);
    do_read(22'h000401, 0, 1, 0);
    // random mix over a small address pool
    for (int n = 0; n < 40; n++) begin
      logic [ADDR_W-1:0] a;
      a = {12'($urandom_range(0, 3)), 10'($urandom_range(0, 3))};
      if ($urandom_range(0, 1) == 1) do_write(a, {$urandom, $urandom}, int'($urandom_range(0, 3)));
      else do_read(a, int'($urandom_range(0, 4)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule